// File: doc/BRIEF.md
# Drift-Compensated Numerically Controlled Oscillator

This block is a 64-bit phase-accumulator oscillator that runs from a local clock known to carry offset and drift. It measures that drift against a stable reference clock and rescales the phase step in hardware. The phase step is not a fixed programmed constant.

A measurement window is a fixed number of local-clock cycles. During each window a counter in the reference domain counts reference edges. At the end of the window the block passes that count back to the local domain through a toggle request/acknowledge synchronizer. It then forms the product of the window length and the nominal phase step, and divides that product by the reference count in a bit-serial restoring divider. The divider produces one quotient bit per cycle.

The quotient goes into a shadow register. It replaces the live phase step in a single cycle only once the division has finished. If the reference clock delivers no edges, the live step is held and an error flag is raised.

Top module: `nco_dc_top`

## Requirements
- R1: While `rstN` is low, the accumulator is loaded with `initPhase` and the live phase step with `nominalInc`, and `valid`, `errFlag` and `busy` are 0. After release, the step equals `nominalInc` until the first correction goes live.
- R2: On every local clock edge out of reset, the accumulator advances by the live step modulo 2^64. `phaseOut` carries the top OUT_W accumulator bits.
- R3: A window is GATE_CYCLES local cycles. M is the number of reference rising edges between two successive captures. The corrected step is floor(GATE_CYCLES × N / M), where N is the `nominalInc` value sampled when the division starts.
- R4: A new step is applied only after the division has produced every quotient bit. The live step never holds a partial quotient.
- R5: `valid` is a one-cycle pulse in the first cycle in which a new step is live. The accumulator difference from that cycle to the next equals the new step.
- R6: When the quotient exceeds 2^64−1, the step saturates to all ones.
- R7: A window can end while the previous request is still unanswered, which is the case when no reference edges arrive. Then `errFlag` goes to 1, the live step is held, and no `valid` pulse occurs.
- R8: `errFlag` returns to 0 in the cycle the next correction goes live.
- R9: At most one request is outstanding. The reference-side count register changes only on a new request. The late answer to a request that stalled is discarded rather than divided.
- R10: `busy` is 1 from the cycle after a division starts until the result is applied, and 0 in the cycle `valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; drives the accumulator and the divider |
| refClk | input | 1 | Stable reference clock that is counted |
| rstN | input | 1 | Active-low synchronous reset, seen in both clock domains |
| initPhase | input | 64 | Accumulator value loaded during reset |
| nominalInc | input | 64 | Uncorrected phase step |
| phaseOut | output | OUT_W | Most significant accumulator bits |
| busy | output | 1 | Division in progress |
| valid | output | 1 | Pulse: a corrected step has just gone live |
| errFlag | output | 1 | Reference count missing for a window |

## Verification
The bench builds the block with GATE_CYCLES=256, CNT_W=16 and OUT_W=64.

With the full accumulator visible, the applied step can be read exactly as the difference of two consecutive phase samples. The short window lets about twenty corrections fit in a short run.

Reference periods of 20 ns and 16 ns give exact counts of 128 and 160 edges per window. These yield a step ratio of 2, a ratio of 1.6 that exposes truncation, and a product large enough to saturate. Stopping the reference clock drives the stall, error and recovery path.

// File: rtl/nco_dc_pkg.sv
`timescale 1ns/1ps
package nco_dc_pkg;
  localparam int PHASE_W = 64;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic start;    // latch operands, begin division
    logic commit;   // shadow quotient becomes the live step
    logic flagErr;  // window result missing or unusable
  } ncoStrobe_t;

  typedef enum logic {ST_IDLE, ST_DIV} ctrlState_t;
endpackage

// File: rtl/nco_dc_refcnt.sv
`timescale 1ns/1ps
module nco_dc_refcnt #(
  parameter int CNT_W = 20
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             reqTgl,
  output logic             ackTgl,
  output logic [CNT_W-1:0] extCount
);
  logic reqS1, reqS2, reqSeen;
  logic [CNT_W-1:0] edgeCnt;
  logic newReq;

  assign newReq = (reqS2 != reqSeen);

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      reqS1    <= 1'b0;
      reqS2    <= 1'b0;
      reqSeen  <= 1'b0;
      edgeCnt  <= '0;
      extCount <= '0;
      ackTgl   <= 1'b0;
    end else begin
      reqS1   <= reqTgl;
      reqS2   <= reqS1;
      reqSeen <= reqS2;
      if (newReq) begin
        // the capturing edge is counted in this window
        extCount <= (edgeCnt == '1) ? edgeCnt : edgeCnt + 1'b1;
        edgeCnt  <= '0;
        ackTgl   <= reqS2;
      end else if (edgeCnt != '1) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  // R9: the handed-over count is only rewritten on a fresh request
  p_hold_stable_r9: assert property (@(posedge refClk) disable iff (!rstN)
    !newReq |=> $stable(extCount));
endmodule

// File: rtl/nco_dc_ctrl.sv
`timescale 1ns/1ps
module nco_dc_ctrl
  import nco_dc_pkg::*;
#(
  parameter int GATE_CYCLES = 16384,
  parameter int CNT_W       = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ackTgl,
  input  logic [CNT_W-1:0] extCount,
  input  logic             divReady,
  output logic             reqTgl,
  output ncoStrobe_t       strobe,
  output logic             busy,
  output logic             validOut,
  output logic             errOut
);
  localparam int GATE_W = $clog2(GATE_CYCLES);

  logic [GATE_W-1:0] gateCnt;
  logic ackS1, ackS2, ackSeen;
  logic ackEdge, gateEnd, pending, discard;
  ctrlState_t state;

  assign ackEdge = (ackS2 != ackSeen);
  assign gateEnd = (gateCnt == GATE_W'(GATE_CYCLES - 1));
  assign pending = (reqTgl != ackS2);
  assign busy    = (state == ST_DIV);

  always_comb begin
    strobe = '0;
    strobe.start   = ackEdge && !discard && (state == ST_IDLE) && (extCount != '0);
    strobe.flagErr = (gateEnd && pending) || (ackEdge && !discard && (extCount == '0));
    strobe.commit  = (state == ST_DIV) && divReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateCnt  <= '0;
      ackS1    <= 1'b0;
      ackS2    <= 1'b0;
      ackSeen  <= 1'b0;
      reqTgl   <= 1'b0;
      discard  <= 1'b0;
      state    <= ST_IDLE;
      validOut <= 1'b0;
      errOut   <= 1'b0;
    end else begin
      ackS1   <= ackTgl;
      ackS2   <= ackS1;
      ackSeen <= ackS2;
      gateCnt <= gateEnd ? '0 : gateCnt + 1'b1;
      if (gateEnd && !pending) reqTgl <= ~reqTgl;
      if (gateEnd && pending) discard <= 1'b1;
      else if (ackEdge)       discard <= 1'b0;
      case (state)
        ST_IDLE: if (strobe.start)  state <= ST_DIV;
        ST_DIV:  if (strobe.commit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      validOut <= strobe.commit;
      if (strobe.flagErr)     errOut <= 1'b1;
      else if (strobe.commit) errOut <= 1'b0;
    end
  end

  // R9: a new request only when the previous one has been answered
  p_one_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqTgl != $past(reqTgl)) |-> ($past(reqTgl) == $past(ackS2)));
  // R9: an accepted answer never arrives during a division
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackEdge && !discard) |-> !busy);
  // R7: a missing result raises the flag
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagErr |=> errOut);
  // R8: a fresh correction clears the flag
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> !errOut);
  // R5: the update indication lasts a single cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);
  // R10: busy follows a division start
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> busy);
endmodule

// File: rtl/nco_dc_dpath.sv
`timescale 1ns/1ps
module nco_dc_dpath
  import nco_dc_pkg::*;
#(
  parameter int GATE_CYCLES = 16384,
  parameter int CNT_W       = 20,
  parameter int OUT_W       = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ncoStrobe_t         strobe,
  input  logic [PHASE_W-1:0] initPhase,
  input  logic [PHASE_W-1:0] nominalInc,
  input  logic [CNT_W-1:0]   extCount,
  output logic               divReady,
  output logic [OUT_W-1:0]   phaseOut
);
  localparam int PROD_W = PHASE_W + CNT_W;
  localparam int BIT_W  = $clog2(PROD_W);

  logic [PROD_W-1:0]  dvd, quo, product;
  logic [CNT_W-1:0]   rem, divisor;
  logic [CNT_W:0]     trial, remNext;
  logic               fits, overflow, running;
  logic [BIT_W-1:0]   bitCnt;
  logic [PHASE_W-1:0] staged, incLive, phase;

  // multiply first so the division keeps full precision
  assign product  = {{CNT_W{1'b0}}, nominalInc} * PROD_W'(GATE_CYCLES);
  assign trial    = {rem, dvd[PROD_W-1]};
  assign fits     = (trial >= {1'b0, divisor});
  assign remNext  = fits ? (trial - {1'b0, divisor}) : trial;
  assign overflow = |quo[PROD_W-1:PHASE_W];
  assign staged   = overflow ? '1 : quo[PHASE_W-1:0];
  assign phaseOut = phase[PHASE_W-1 -: OUT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvd      <= '0;
      quo      <= '0;
      rem      <= '0;
      divisor  <= '0;
      bitCnt   <= '0;
      running  <= 1'b0;
      divReady <= 1'b0;
    end else if (strobe.start) begin
      dvd      <= product;
      quo      <= '0;
      rem      <= '0;
      divisor  <= extCount;
      bitCnt   <= '0;
      running  <= 1'b1;
      divReady <= 1'b0;
    end else if (running) begin
      dvd    <= dvd << 1;
      quo    <= {quo[PROD_W-2:0], fits};
      rem    <= remNext[CNT_W-1:0];
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == BIT_W'(PROD_W - 1)) begin
        running  <= 1'b0;
        divReady <= 1'b1;
      end
    end else if (strobe.commit) begin
      divReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= initPhase;
      incLive <= nominalInc;
    end else begin
      phase <= phase + incLive;
      if (strobe.commit) incLive <= staged;
    end
  end

  // R4: the live step moves only on a commit
  p_inc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(incLive));
  // R4: a commit is only issued with a complete quotient
  p_commit_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (divReady && !running));
endmodule

// File: rtl/nco_dc_top.sv
`timescale 1ns/1ps
module nco_dc_top
  import nco_dc_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int GATE_CYCLES = 16384,
  parameter int OUT_W       = 16
) (
  input  logic             clk,
  input  logic             refClk,
  input  logic             rstN,
  input  logic [63:0]      initPhase,
  input  logic [63:0]      nominalInc,
  output logic [OUT_W-1:0] phaseOut,
  output logic             busy,
  output logic             valid,
  output logic             errFlag
);
  logic             reqTgl, ackTgl, divReady;
  logic [CNT_W-1:0] extCount;
  ncoStrobe_t       strobe;

  nco_dc_refcnt #(.CNT_W(CNT_W)) refcnt_i (
    .refClk(refClk), .rstN(rstN), .reqTgl(reqTgl),
    .ackTgl(ackTgl), .extCount(extCount));

  nco_dc_ctrl #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ackTgl(ackTgl), .extCount(extCount),
    .divReady(divReady), .reqTgl(reqTgl), .strobe(strobe),
    .busy(busy), .validOut(valid), .errOut(errFlag));

  nco_dc_dpath #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W), .OUT_W(OUT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .initPhase(initPhase),
    .nominalInc(nominalInc), .extCount(extCount), .divReady(divReady),
    .phaseOut(phaseOut));
endmodule

// File: tb/nco_dc_top_tb_top.sv
`timescale 1ns/1ps
module nco_dc_top_tb_top;
  localparam int CNT_W = 16;
  localparam int GATE  = 256;
  localparam int OUT_W = 64;

  localparam logic [63:0] N0   = 64'h0000_0100_0000_0000;
  localparam logic [63:0] N1   = 64'h0000_0000_0123_4567;
  localparam logic [63:0] NBIG = 64'hC000_0000_0000_0000;
  localparam logic [63:0] INIT = 64'hFFFF_FF00_0000_1234;

  logic clk = 1'b0, refClk = 1'b0, rstN = 1'b0;
  logic [63:0] initPhase = INIT, nominalInc = N0;
  logic [OUT_W-1:0] phaseOut;
  logic busy, valid, errFlag;

  int checks = 0, fails = 0, validCount = 0;
  bit refRun = 1'b1;
  int refHalf = 10;
  logic [63:0] expQ[$];

  nco_dc_top #(.CNT_W(CNT_W), .GATE_CYCLES(GATE), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .refClk(refClk), .rstN(rstN), .initPhase(initPhase),
    .nominalInc(nominalInc), .phaseOut(phaseOut), .busy(busy),
    .valid(valid), .errFlag(errFlag));

  always #5 clk = ~clk;

  initial begin
    #3;
    forever begin
      #(refHalf);
      if (refRun) refClk = ~refClk;
    end
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic waitValids(input int n);
    int target;
    target = validCount + n;
    while (validCount < target) @(negedge clk);
  endtask

  task automatic measureStep(output logic [63:0] s);
    logic [63:0] p0;
    @(negedge clk) p0 = phaseOut;
    @(negedge clk) s = phaseOut - p0;
  endtask

  task automatic pushExp(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(v);
  endtask

  // monitor: measures each newly applied step and scores it
  initial begin
    logic [63:0] p0, step, exp;
    forever begin
      @(negedge clk);
      if (rstN && valid) begin
        p0 = phaseOut;
        check64("R10 busy low at update", {63'd0, busy}, 64'd0);
        @(negedge clk);
        step = phaseOut - p0;
        check64("R5 valid single cycle", {63'd0, valid}, 64'd0);
        if (expQ.size() > 0) begin
          exp = expQ.pop_front();
          check64("R3/R4/R6 applied step", step, exp);
        end
        validCount++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] s, eFrac;
    logic [127:0] wide;
    int vc0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check64("R1 phase in reset", phaseOut, INIT);
    check64("R1 valid in reset", {63'd0, valid}, 64'd0);
    check64("R1 err in reset", {63'd0, errFlag}, 64'd0);
    check64("R1 busy in reset", {63'd0, busy}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 wrap modulo 2^64 on the first step
    check64("R2 first step wraps", phaseOut, INIT + N0);
    measureStep(s);
    check64("R1 nominal step before correction", s, N0);
    measureStep(s);
    check64("R2 steady accumulation", s, N0);

    // R3 ratio 2 (128 reference edges per 256-cycle window)
    waitValids(2);
    pushExp(N0 << 1, 3);
    waitValids(3);

    // R3 with a different nominal value
    nominalInc = N1;
    waitValids(2);
    pushExp(N1 << 1, 2);
    waitValids(2);

    // R3 truncation: 160 edges per window
    refHalf = 8;
    waitValids(3);
    wide = ({64'd0, N1} * 128'd256) / 128'd160;
    eFrac = wide[63:0];
    pushExp(eFrac, 2);
    waitValids(2);

    // R6 saturation
    refHalf = 10;
    nominalInc = NBIG;
    waitValids(3);
    pushExp('1, 2);
    waitValids(2);

    // R7 stall of the reference clock
    nominalInc = N0;
    waitValids(3);
    pushExp(N0 << 1, 1);
    waitValids(1);
    refRun = 1'b0;
    vc0 = validCount;
    repeat (4 * GATE) @(negedge clk);
    check64("R7 error flag raised", {63'd0, errFlag}, 64'd1);
    measureStep(s);
    check64("R7 step held", s, N0 << 1);
    check64("R7 no update while stalled", 64'(validCount), 64'(vc0));

    // R8 recovery clears the flag; R9 stale answer dropped, then steady again
    refRun = 1'b1;
    waitValids(1);
    check64("R8 error cleared by update", {63'd0, errFlag}, 64'd0);
    waitValids(2);
    pushExp(N0 << 1, 2);
    waitValids(2);
    check64("R9 scoreboard drained", 64'(expQ.size()), 64'd0);
    summary();
  end
endmodule